// File: doc/BRIEF.md
# Time-Slot Serial Port Controller

This block moves one codec channel's data on and off a pair of serial time-slot lines for a PCM/ADPCM transcoder. A frame sync restarts a bit-position counter. The channel's direction control sets the slot width on each side. In compress mode the receive side carries 8-bit PCM slots and the transmit side carries 4-bit ADPCM slots. In expand mode the two sides swap. The companding-law control selects the frame length, so it also sets how many slots fit in a frame.

At the chosen receive slot the block shifts in one word from the serial input and presents it as a parallel word with a one-cycle strobe. At the chosen transmit slot it loads a parallel word and shifts it out MSB first, with an output enable that is high only during that slot. Slot numbers come from register inputs. A hardware-strap input forces both slot numbers to zero. An idle input stops all transfers on the channel while the bit counter keeps running.

Top module: `tslot_port`

## Requirements
- R1: A frame sync sampled high on a rising edge sets the bit position to 0. The next rising edge samples frame bit 0. A frame sync in the middle of a frame restarts counting from bit 0.
- R2: In compress mode (`compress`=1) the receive side has frame/8 slots of 8 bits and the transmit side has frame/4 slots of 4 bits. Slot n covers bits n*w to n*w+w-1.
- R3: In expand mode (`compress`=0) the receive side has frame/4 slots of 4 bits and the transmit side has frame/8 slots of 8 bits.
- R4: The receive word is taken in MSB first. `rx_valid` is high for exactly one cycle, in the cycle after the edge that samples the slot's last bit, and `rx_word` then holds the word. A 4-bit word sits in `rx_word[3:0]` with the upper bits zero.
- R5: `sdout_oe` is high exactly during the bits of the transmit slot, and `sdout` gives the word MSB first. For a 4-bit slot `sdout` uses `tx_word[3:0]`. `tx_word` is sampled on the rising edge that begins the slot, so later changes to it have no effect. `sdout` is 0 whenever `sdout_oe` is low.
- R6: While `hw_mode` is 1, both slots are slot 0 and `rx_slot`/`tx_slot` are ignored.
- R7: While `idle` is 1, no `rx_valid` pulse occurs and `sdout_oe` stays low.
- R8: `law_mu`=1 selects a frame of MU_FRAME_BITS bits and `law_mu`=0 selects A_FRAME_BITS bits (both default 256). No transfer occurs before the first frame sync, or after the last frame bit until the next sync.
- R9: A slot number at or beyond the slot count for the current mode is taken modulo that count.
- R10: During reset `rx_valid`, `sdout_oe` and `sdout` are 0 and `rx_word` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial data clock; all sampling on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsync | input | 1 | Frame sync |
| law_mu | input | 1 | Companding law: 1 mu-law, 0 A-law (selects frame length) |
| compress | input | 1 | Direction: 1 compress, 0 expand |
| hw_mode | input | 1 | Hardware strap: forces both slots to 0 |
| idle | input | 1 | Suppresses all transfers |
| rx_slot | input | SLOT_W | Receive slot number |
| tx_slot | input | SLOT_W | Transmit slot number |
| sdin | input | 1 | Serial input data |
| tx_word | input | PCM_W | Parallel word to transmit |
| rx_word | output | PCM_W | Last received word |
| rx_valid | output | 1 | One-cycle strobe: new `rx_word` |
| sdout | output | 1 | Serial output data |
| sdout_oe | output | 1 | Output enable for `sdout`; low means high impedance |

## Verification
The bench builds the block with MU_FRAME_BITS=256 and A_FRAME_BITS=128. Because the two frame lengths differ, the law input has a visible effect on the slot counts. The modulo wrap of slot numbers then differs between the two laws. With the shorter frame, the counter stops well before the next sync, so the quiet gap is exercised. It also tests the last slot ending exactly on the final frame bit for both frame lengths.

// File: rtl/tslot_port.sv
module tslot_port #(
  parameter int PCM_W         = 8,
  parameter int ADPCM_W       = 4,
  parameter int MU_FRAME_BITS = 256,
  parameter int A_FRAME_BITS  = 256,
  localparam int MAXF   = (MU_FRAME_BITS > A_FRAME_BITS) ? MU_FRAME_BITS : A_FRAME_BITS,
  localparam int SLOT_W = $clog2(MAXF / ADPCM_W),
  localparam int CW     = $clog2(MAXF) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fsync,
  input  logic              law_mu,
  input  logic              compress,
  input  logic              hw_mode,
  input  logic              idle,
  input  logic [SLOT_W-1:0] rx_slot,
  input  logic [SLOT_W-1:0] tx_slot,
  input  logic              sdin,
  input  logic [PCM_W-1:0]  tx_word,
  output logic [PCM_W-1:0]  rx_word,
  output logic              rx_valid,
  output logic              sdout,
  output logic              sdout_oe
);
  localparam int PCM_LG = $clog2(PCM_W);
  localparam int ADP_LG = $clog2(ADPCM_W);
  localparam logic [CW-1:0] MU_LEN = CW'(MU_FRAME_BITS);
  localparam logic [CW-1:0] A_LEN  = CW'(A_FRAME_BITS);
  localparam logic [CW-1:0] PCM_WC = CW'(PCM_W);
  localparam logic [CW-1:0] ADP_WC = CW'(ADPCM_W);

  logic [CW-1:0]    pos;
  logic             run;
  logic [CW-1:0]    flen, in_w, out_w, in_cnt, out_cnt;
  logic [CW-1:0]    in_start, out_start, in_off, out_off;
  logic [4:0]       in_lg, out_lg;
  logic             in_win, out_win, tx_load;
  logic [PCM_W-1:0] sh, sh_nxt, txw;
  logic [PCM_LG-1:0] tx_bit;

  assign flen    = law_mu ? MU_LEN : A_LEN;
  assign in_w    = compress ? PCM_WC : ADP_WC;
  assign out_w   = compress ? ADP_WC : PCM_WC;
  assign in_lg   = compress ? 5'(PCM_LG) : 5'(ADP_LG);
  assign out_lg  = compress ? 5'(ADP_LG) : 5'(PCM_LG);
  assign in_cnt  = flen >> in_lg;
  assign out_cnt = flen >> out_lg;

  assign in_start  = hw_mode ? '0 : ((CW'(rx_slot) & (in_cnt - 1'b1)) << in_lg);
  assign out_start = hw_mode ? '0 : ((CW'(tx_slot) & (out_cnt - 1'b1)) << out_lg);

  assign in_off  = pos - in_start;
  assign out_off = pos - out_start;
  assign in_win  = run && !fsync && (pos >= in_start) && (in_off < in_w);
  assign out_win = run && (pos >= out_start) && (out_off < out_w);

  assign sdout_oe = out_win && !idle;
  assign tx_bit   = PCM_LG'(out_w - 1'b1 - out_off);
  assign sdout    = sdout_oe & txw[tx_bit];

  assign tx_load = fsync ? (out_start == '0) : (run && (pos + 1'b1 == out_start));
  assign sh_nxt  = (in_off == '0) ? PCM_W'(sdin) : {sh[PCM_W-2:0], sdin};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos      <= '0;
      run      <= 1'b0;
      sh       <= '0;
      txw      <= '0;
      rx_word  <= '0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (fsync) begin
        pos <= '0;
        run <= 1'b1;
      end else if (run) begin
        if (pos == flen - 1'b1) run <= 1'b0;
        else                    pos <= pos + 1'b1;
      end
      if (tx_load) txw <= tx_word;
      if (in_win && !idle) begin
        sh <= sh_nxt;
        if (in_off == in_w - 1'b1) begin
          rx_word  <= sh_nxt;
          rx_valid <= 1'b1;
        end
      end
    end
  end

  AST_SYNC_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    fsync |=> !rx_valid); // R1
  AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid); // R4
  AST_HW_SLOT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_mode && sdout_oe) |-> (pos < out_w)); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> !sdout_oe); // R7
  AST_STROBE_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(run)); // R8
  AST_OUT_LOW_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !sdout_oe |-> !sdout); // R5
endmodule

// File: tb/sim_tslot_port.sv
module sim_tslot_port;
  localparam int MU_F = 256;
  localparam int A_F  = 128;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n = 1'b0, fsync = 1'b0, law_mu = 1'b1, compress = 1'b1;
  logic       hw_mode = 1'b0, idle = 1'b0, sdin = 1'b0;
  logic [5:0] rx_slot = '0, tx_slot = '0;
  logic [7:0] tx_word = '0;
  logic [7:0] rx_word;
  logic       rx_valid, sdout, sdout_oe;

  tslot_port #(.PCM_W(8), .ADPCM_W(4), .MU_FRAME_BITS(MU_F), .A_FRAME_BITS(A_F)) u0 (
    .clk(clk), .rst_n(rst_n), .fsync(fsync), .law_mu(law_mu), .compress(compress),
    .hw_mode(hw_mode), .idle(idle), .rx_slot(rx_slot), .tx_slot(tx_slot), .sdin(sdin),
    .tx_word(tx_word), .rx_word(rx_word), .rx_valid(rx_valid), .sdout(sdout),
    .sdout_oe(sdout_oe)
  );

  int    vectors = 0, errs = 0;
  string cur_req = "R10";
  int    mpos = -1, acc = 0, e_word = 0, etx = 0;
  bit    e_valid = 1'b0;

  function automatic int slot_start(int slot, int w);
    int fl;
    fl = law_mu ? MU_F : A_F;
    return hw_mode ? 0 : (slot % (fl / w)) * w;
  endfunction

  task automatic miss(string what, int act, int exp);
    errs++;
    $display("FAIL %s %s: got %0h expected %0h", cur_req, what, act, exp);
  endtask

  always @(posedge clk or negedge rst_n) begin
    int fl, iw, ow, is, os;
    if (!rst_n) begin
      mpos = -1; e_valid = 0; e_word = 0; etx = 0;
    end else begin
      fl = law_mu ? MU_F : A_F;
      iw = compress ? 8 : 4;
      ow = compress ? 4 : 8;
      is = slot_start(rx_slot, iw);
      os = slot_start(tx_slot, ow);
      e_valid = 0;
      if (fsync) begin
        mpos = 0;
        if (os == 0) etx = tx_word;
      end else if (mpos >= 0) begin
        if (!idle && mpos >= is && mpos < is + iw) begin
          acc = (mpos == is) ? int'(sdin) : ((acc << 1) | int'(sdin));
          if (mpos == is + iw - 1) begin e_valid = 1; e_word = acc; end
        end
        if (mpos == fl - 1) mpos = -1;
        else begin
          mpos = mpos + 1;
          if (mpos == os) etx = tx_word;
        end
      end
    end
  end

  always @(negedge clk) begin
    int ow, os, ebit;
    bit eoe;
    vectors++;
    ow  = compress ? 4 : 8;
    os  = slot_start(tx_slot, ow);
    eoe = rst_n && mpos >= 0 && mpos >= os && mpos < os + ow && !idle;
    if (sdout_oe !== eoe) miss("sdout_oe", int'(sdout_oe), int'(eoe));
    else begin
      ebit = eoe ? ((etx >> (ow - 1 - (mpos - os))) & 1) : 0;
      if (sdout !== 1'(ebit)) miss("sdout", int'(sdout), ebit);
    end
    if (rx_valid !== e_valid) miss("rx_valid", int'(rx_valid), int'(e_valid));
    else if (e_valid && rx_word !== 8'(e_word)) miss("rx_word", int'(rx_word), e_word);
  end

  task automatic step();
    sdin    = 1'($urandom);
    tx_word = 8'($urandom);
    @(posedge clk);
    #2;
  endtask

  task automatic frame(int n);
    fsync = 1'b1;
    step();
    fsync = 1'b0;
    repeat (n) step();
  endtask

  task automatic setup(bit lw, bit cp, bit hw, bit id, int rs, int ts);
    law_mu = lw; compress = cp; hw_mode = hw; idle = id;
    rx_slot = 6'(rs); tx_slot = 6'(ts);
  endtask

  initial begin
    #2000000;
    errs++;
    $display("FAIL watchdog: got hang expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end

  initial begin
    cur_req = "R10";
    repeat (3) @(posedge clk);
    @(negedge clk);
    vectors++;
    if (rx_word !== 8'h00) miss("rx_word reset", int'(rx_word), 0);
    @(posedge clk); #2;
    rst_n = 1'b1;
    cur_req = "R8";  repeat (20) step();
    cur_req = "R2";  setup(1, 1, 0, 0, 3, 10); frame(MU_F); frame(MU_F);
    cur_req = "R4";  setup(1, 1, 0, 0, 0, 0);  frame(MU_F);
    setup(1, 1, 0, 0, 31, 63); frame(MU_F);
    cur_req = "R3";  setup(1, 0, 0, 0, 5, 2);  frame(MU_F);
    setup(1, 0, 0, 0, 63, 31); frame(MU_F);
    cur_req = "R9";  setup(1, 1, 0, 0, 37, 45); frame(MU_F);
    setup(1, 0, 0, 0, 40, 45); frame(MU_F);
    cur_req = "R5";  setup(1, 1, 0, 0, 7, 1);  frame(MU_F);
    setup(1, 0, 0, 0, 1, 7); frame(MU_F);
    cur_req = "R6";  setup(1, 1, 1, 0, 9, 20); frame(MU_F);
    setup(1, 0, 1, 0, 33, 17); frame(MU_F);
    cur_req = "R7";  setup(1, 1, 0, 1, 4, 6);  frame(MU_F);
    setup(1, 1, 0, 0, 4, 6); frame(MU_F);
    cur_req = "R8";  setup(0, 1, 0, 0, 15, 31); frame(A_F + 60);
    setup(0, 0, 0, 0, 40, 20); frame(A_F);
    setup(0, 1, 0, 0, 16, 32); frame(A_F);
    cur_req = "R1";  setup(1, 1, 0, 0, 2, 30); frame(100); frame(MU_F);
    frame(MU_F);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end
endmodule